// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a wide set of maskable peripheral interrupt requests and a small set of nonmaskable trap requests, and reduces them to one request toward the CPU. Each maskable source has an enable bit and a three-bit programmable priority, where priority 0 means the source is off. A source is forwarded only when its level is strictly above the CPU's current priority. Traps always outrank maskable sources. Within one level, the source with the lower vector number wins.

Every request line sets a pending flag. The flag stays set until the CPU acknowledges that exact vector. The winning vector number, its level and the program address of its vector entry are presented on registered outputs. A single select input moves every lookup from the primary table to an alternate table with the same layout. On acknowledge, the block latches the presented vector, level and address into a separate set of outputs. These stay frozen until the next accepted acknowledge.

Top module: `vpic_top`

## Requirements
- R1: A qualifying request driven before a clock edge shows on `irq_out` right after that edge, with its vector on `irq_vec`. Arbitration adds no further cycle.
- R2: A maskable source is forwarded only when its enable bit is 1, its priority is nonzero, and its priority is strictly greater than `cpu_prio`. Otherwise `irq_out` stays 0 for it.
- R3: Among qualifying maskable sources, the one with the highest programmed priority wins, whatever its index.
- R4: Among qualifying sources at the same priority, the lowest source index wins.
- R5: Any pending trap wins over every maskable source, whatever `cpu_prio` or the enables. The lowest trap index wins among traps. A trap is reported with level 8.
- R6: Trap t has vector number t. Maskable source i has vector number 8+i.
- R7: The vector address is the table base plus 2 times the vector number. The base is 0x000004 when `alt_sel` is 0 and 0x000104 when it is 1.
- R8: A pending flag survives while its source is blocked. Enabling the source or raising its priority later makes it win without a new request.
- R9: When `cpu_ack` is high at an edge while `irq_out` is 1, the presented vector, level and address are copied to `ack_vec`, `ack_lvl` and `ack_addr`. The same edge clears that vector's pending flag, unless a new request for it arrives in that same cycle.
- R10: Without an accepted acknowledge, `ack_vec`, `ack_lvl` and `ack_addr` keep their values. An acknowledge while `irq_out` is 0 changes nothing.
- R11: After reset, `irq_out` is 0 and all acknowledge outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 5 | Trap request lines, index = trap number |
| irq_req | input | 61 | Maskable request lines |
| irq_en | input | 61 | Per-source enable bits |
| irq_prio | input | 183 | Per-source priority, 3 bits per source, source i at bits 3i+2..3i |
| cpu_prio | input | 3 | Current CPU priority |
| alt_sel | input | 1 | Selects the alternate vector table |
| cpu_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_out | output | 1 | Request to the CPU |
| irq_vec | output | 7 | Presented vector number |
| irq_lvl | output | 4 | Presented level (8 for traps) |
| irq_addr | output | 24 | Program address of the presented vector entry |
| ack_vec | output | 7 | Vector latched at the last acknowledge |
| ack_lvl | output | 4 | Level latched at the last acknowledge |
| ack_addr | output | 24 | Entry address latched at the last acknowledge |

## Verification
Two events can land on the same edge. The first is the clearing of an acknowledged pending flag together with a fresh request for that same source. The bench drives `cpu_ack` and the request line in one cycle, and it requires the same vector to be presented again afterwards. The second is a trap arriving in the same cycle as a maskable request at the top user level. The bench requires the trap to be served first, and the maskable one only once `cpu_prio` allows it. A scoreboard queue holds the expected vector, level and address for each acknowledge, and compares them against the latched outputs.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   localparam int PRIO_W = 3;
   localparam int LVL_W  = PRIO_W + 1;
   localparam int VEC_W  = 7;
   localparam int ADDR_W = 24;
   localparam logic [LVL_W-1:0] TRAP_LVL = LVL_W'(1 << PRIO_W);

   typedef struct packed {
      logic              hit;
      logic [VEC_W-1:0]  vec;
      logic [LVL_W-1:0]  lvl;
   } win_t;
endpackage

// File: rtl/vpic_pend.sv
module vpic_pend #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] eff_o
);
   logic [W-1:0] flag_q;

   // a fresh request in the clearing cycle re-arms the flag
   assign eff_o = (flag_q & ~clr_i) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= eff_o;
   end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
   import vpic_pkg::*;
#(
   parameter int N_TRAP     = 5,
   parameter int N_IRQ      = 61,
   parameter int TRAP_SLOTS = 8
) (
   input  logic [N_TRAP-1:0]       trap_eff,
   input  logic [N_IRQ-1:0]        irq_eff,
   input  logic [N_IRQ-1:0]        irq_en,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0]       cpu_prio,
   output win_t                    win
);
   localparam int IDX_W = $clog2(N_IRQ + 1);

   logic [N_IRQ-1:0]  qual;
   logic [PRIO_W-1:0] best_lvl;
   logic              user_hit;
   logic [IDX_W-1:0]  user_idx;
   logic              trap_hit;
   logic [VEC_W-1:0]  trap_idx;

   genvar g;
   generate
      for (g = 0; g < N_IRQ; g++) begin : g_qual
         logic [PRIO_W-1:0] p;
         assign p       = irq_prio[g*PRIO_W +: PRIO_W];
         assign qual[g] = irq_eff[g] & irq_en[g] & (p != '0) & (p > cpu_prio);
      end
   endgenerate

   // stage one: highest programmed level among qualifying sources
   always_comb begin
      best_lvl = '0;
      for (int i = 0; i < N_IRQ; i++) begin
         if (qual[i] && (irq_prio[i*PRIO_W +: PRIO_W] > best_lvl))
            best_lvl = irq_prio[i*PRIO_W +: PRIO_W];
      end
   end

   // stage two: lowest index at that level
   always_comb begin
      user_hit = 1'b0;
      user_idx = '0;
      for (int i = 0; i < N_IRQ; i++) begin
         if (!user_hit && qual[i] && (irq_prio[i*PRIO_W +: PRIO_W] == best_lvl)) begin
            user_hit = 1'b1;
            user_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      trap_hit = 1'b0;
      trap_idx = '0;
      for (int t = 0; t < N_TRAP; t++) begin
         if (!trap_hit && trap_eff[t]) begin
            trap_hit = 1'b1;
            trap_idx = VEC_W'(t);
         end
      end
   end

   always_comb begin
      win = '0;
      if (trap_hit) begin
         win.hit = 1'b1;
         win.vec = trap_idx;
         win.lvl = TRAP_LVL;
      end else if (user_hit) begin
         win.hit = 1'b1;
         win.vec = VEC_W'(TRAP_SLOTS) + VEC_W'(user_idx);
         win.lvl = LVL_W'(best_lvl);
      end
   end
endmodule

// File: rtl/vpic_vmap.sv
module vpic_vmap
   import vpic_pkg::*;
#(
   parameter logic [ADDR_W-1:0] PRI_BASE   = 24'h000004,
   parameter logic [ADDR_W-1:0] ALT_OFFSET = 24'h000100
) (
   input  logic [VEC_W-1:0]  vec,
   input  logic              alt,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] ALT_BASE = PRI_BASE + ALT_OFFSET;

   logic [ADDR_W-1:0] step;
   assign step = ADDR_W'(vec) << 1;

   generate
      if (ALT_OFFSET == '0) begin : g_single
         logic unused_alt;
         assign unused_alt = alt;
         assign addr = PRI_BASE + step;
      end else begin : g_dual
         assign addr = (alt ? ALT_BASE : PRI_BASE) + step;
      end
   endgenerate
endmodule

// File: rtl/vpic_top.sv
module vpic_top
   import vpic_pkg::*;
#(
   parameter int N_TRAP     = 5,
   parameter int N_IRQ      = 61,
   parameter int TRAP_SLOTS = 8,
   parameter logic [ADDR_W-1:0] PRI_BASE   = 24'h000004,
   parameter logic [ADDR_W-1:0] ALT_OFFSET = 24'h000100
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_TRAP-1:0]       trap_req,
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_en,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0]       cpu_prio,
   input  logic                    alt_sel,
   input  logic                    cpu_ack,
   output logic                    irq_out,
   output logic [VEC_W-1:0]        irq_vec,
   output logic [LVL_W-1:0]        irq_lvl,
   output logic [ADDR_W-1:0]       irq_addr,
   output logic [VEC_W-1:0]        ack_vec,
   output logic [LVL_W-1:0]        ack_lvl,
   output logic [ADDR_W-1:0]       ack_addr
);
   initial begin
      assert (N_TRAP >= 1 && N_TRAP <= TRAP_SLOTS)
         else $error("trap count must fit the trap slots");
      assert (N_IRQ >= 1 && TRAP_SLOTS + N_IRQ <= (1 << VEC_W))
         else $error("vector space too small");
   end

   logic              take;
   logic [N_TRAP-1:0] trap_clr, trap_eff;
   logic [N_IRQ-1:0]  irq_clr, irq_eff;
   win_t              win;
   logic [ADDR_W-1:0] win_addr;

   assign take = cpu_ack & irq_out;

   genvar g;
   generate
      for (g = 0; g < N_TRAP; g++) begin : g_tclr
         assign trap_clr[g] = take && (irq_vec == VEC_W'(g));
      end
      for (g = 0; g < N_IRQ; g++) begin : g_iclr
         assign irq_clr[g] = take && (irq_vec == VEC_W'(TRAP_SLOTS + g));
      end
   endgenerate

   vpic_pend #(.W(N_TRAP)) u_tpend (
      .clk(clk), .rst_n(rst_n), .set_i(trap_req), .clr_i(trap_clr), .eff_o(trap_eff));

   vpic_pend #(.W(N_IRQ)) u_ipend (
      .clk(clk), .rst_n(rst_n), .set_i(irq_req), .clr_i(irq_clr), .eff_o(irq_eff));

   vpic_arb #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .TRAP_SLOTS(TRAP_SLOTS)) u_arb (
      .trap_eff(trap_eff), .irq_eff(irq_eff), .irq_en(irq_en),
      .irq_prio(irq_prio), .cpu_prio(cpu_prio), .win(win));

   vpic_vmap #(.PRI_BASE(PRI_BASE), .ALT_OFFSET(ALT_OFFSET)) u_vmap (
      .vec(win.vec), .alt(alt_sel), .addr(win_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out  <= 1'b0;
         irq_vec  <= '0;
         irq_lvl  <= '0;
         irq_addr <= '0;
      end else begin
         irq_out  <= win.hit;
         irq_vec  <= win.hit ? win.vec : '0;
         irq_lvl  <= win.hit ? win.lvl : '0;
         irq_addr <= win.hit ? win_addr : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_vec  <= '0;
         ack_lvl  <= '0;
         ack_addr <= '0;
      end else if (take) begin
         ack_vec  <= irq_vec;
         ack_lvl  <= irq_lvl;
         ack_addr <= irq_addr;
      end
   end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
   import vpic_pkg::*;
#(
   parameter int TRAP_SLOTS = 8,
   parameter logic [ADDR_W-1:0] PRI_BASE   = 24'h000004,
   parameter logic [ADDR_W-1:0] ALT_OFFSET = 24'h000100
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PRIO_W-1:0] cpu_prio,
   input logic              alt_sel,
   input logic              cpu_ack,
   input logic              irq_out,
   input logic [VEC_W-1:0]  irq_vec,
   input logic [LVL_W-1:0]  irq_lvl,
   input logic [ADDR_W-1:0] irq_addr,
   input logic [VEC_W-1:0]  ack_vec,
   input logic [LVL_W-1:0]  ack_lvl,
   input logic [ADDR_W-1:0] ack_addr
);
   AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && irq_out) |=> (ack_vec == $past(irq_vec) && ack_lvl == $past(irq_lvl)
                                && ack_addr == $past(irq_addr))); // R9

   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ack && irq_out) |=> ($stable(ack_vec) && $stable(ack_lvl) && $stable(ack_addr))); // R10

   AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && irq_vec < VEC_W'(TRAP_SLOTS)) |-> irq_lvl == TRAP_LVL); // R5

   AST_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && irq_vec >= VEC_W'(TRAP_SLOTS)) |->
         (irq_lvl > LVL_W'($past(cpu_prio)) && irq_lvl < TRAP_LVL)); // R2

   AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> irq_addr == (($past(alt_sel) ? PRI_BASE + ALT_OFFSET : PRI_BASE)
                               + (ADDR_W'(irq_vec) << 1))); // R7
endmodule

bind vpic_top vpic_chk #(.TRAP_SLOTS(TRAP_SLOTS), .PRI_BASE(PRI_BASE), .ALT_OFFSET(ALT_OFFSET)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_prio(cpu_prio), .alt_sel(alt_sel), .cpu_ack(cpu_ack),
   .irq_out(irq_out), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .irq_addr(irq_addr),
   .ack_vec(ack_vec), .ack_lvl(ack_lvl), .ack_addr(ack_addr));

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;
   localparam int NT = 5;
   localparam int NI = 61;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0]   trap_req = '0;
   logic [NI-1:0]   irq_req = '0;
   logic [NI-1:0]   irq_en = '0;
   logic [NI*3-1:0] irq_prio = '0;
   logic [2:0]      cpu_prio = '0;
   logic            alt_sel = 1'b0;
   logic            cpu_ack = 1'b0;
   logic            irq_out;
   logic [6:0]      irq_vec, ack_vec;
   logic [3:0]      irq_lvl, ack_lvl;
   logic [23:0]     irq_addr, ack_addr;

   always #4 clk = ~clk;

   vpic_top u0 (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req), .irq_en(irq_en),
      .irq_prio(irq_prio), .cpu_prio(cpu_prio), .alt_sel(alt_sel), .cpu_ack(cpu_ack),
      .irq_out(irq_out), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .irq_addr(irq_addr),
      .ack_vec(ack_vec), .ack_lvl(ack_lvl), .ack_addr(ack_addr));

   int checks = 0;
   int fails = 0;
   bit ended = 1'b0;

   typedef struct { int vec; int lvl; int addr; string tag; } exp_t;
   exp_t q[$];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int vaddr(input int v, input bit alt);
      return (alt ? 'h104 : 'h4) + 2 * v;
   endfunction

   task automatic push(input int v, input int l, input string tag);
      exp_t e;
      e.vec = v; e.lvl = l; e.addr = vaddr(v, alt_sel); e.tag = tag;
      q.push_back(e);
   endtask

   task automatic set_src(input int i, input bit en, input int p);
      irq_en[i] = en;
      irq_prio[i*3 +: 3] = p[2:0];
   endtask

   task automatic pulse_irq(input int i);
      irq_req[i] = 1'b1;
      @(negedge clk);
      irq_req[i] = 1'b0;
   endtask

   task automatic pulse_trap(input int t);
      trap_req[t] = 1'b1;
      @(negedge clk);
      trap_req[t] = 1'b0;
   endtask

   task automatic ack();
      cpu_ack = 1'b1;
      @(negedge clk);
      cpu_ack = 1'b0;
   endtask

   // monitor: compare latched acknowledge outputs with the scoreboard
   logic took = 1'b0;
   always @(posedge clk) took <= rst_n && cpu_ack && irq_out;

   always @(negedge clk) begin
      if (took) begin
         if (q.size() == 0) begin
            chk("R9 unexpected acknowledge", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " ack_vec"}, int'(ack_vec), e.vec);
            chk({e.tag, " ack_lvl"}, int'(ack_lvl), e.lvl);
            chk({e.tag, " ack_addr"}, int'(ack_addr), e.addr);
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 irq_out", int'(irq_out), 0);
      chk("R11 ack_vec", int'(ack_vec), 0);
      chk("R11 ack_lvl", int'(ack_lvl), 0);
      chk("R11 ack_addr", int'(ack_addr), 0);

      // R1 R6 R7: single source, one-cycle latency
      set_src(5, 1'b1, 3);
      pulse_irq(5);
      chk("R1 irq_out", int'(irq_out), 1);
      chk("R6 irq_vec", int'(irq_vec), 13);
      chk("R7 irq_addr", int'(irq_addr), 30);
      push(13, 3, "R9 src5");
      ack();
      chk("R9 cleared", int'(irq_out), 0);

      // R2 enable gating, R8 pending kept
      set_src(7, 1'b0, 4);
      pulse_irq(7);
      chk("R2 disabled", int'(irq_out), 0);
      set_src(7, 1'b1, 4);
      @(negedge clk);
      chk("R8 enabled later", int'(irq_vec), 15);
      push(15, 4, "R8 src7");
      ack();

      // R2 priority zero
      set_src(9, 1'b1, 0);
      pulse_irq(9);
      @(negedge clk);
      chk("R2 prio zero", int'(irq_out), 0);
      set_src(9, 1'b1, 1);
      @(negedge clk);
      chk("R8 prio raised", int'(irq_vec), 17);
      push(17, 1, "R8 src9");
      ack();

      // R2 cpu priority masking
      cpu_prio = 3'd4;
      set_src(3, 1'b1, 4);
      pulse_irq(3);
      @(negedge clk);
      chk("R2 equal to cpu", int'(irq_out), 0);
      cpu_prio = 3'd3;
      @(negedge clk);
      chk("R2 above cpu", int'(irq_vec), 11);
      push(11, 4, "R2 src3");
      ack();
      cpu_prio = 3'd0;

      // R3 higher level beats lower index
      set_src(2, 1'b1, 2);
      set_src(40, 1'b1, 6);
      irq_req[2] = 1'b1; irq_req[40] = 1'b1;
      @(negedge clk);
      irq_req[2] = 1'b0; irq_req[40] = 1'b0;
      chk("R3 high level first", int'(irq_vec), 48);
      push(48, 6, "R3 src40");
      ack();
      chk("R3 then low level", int'(irq_vec), 10);
      push(10, 2, "R3 src2");
      ack();

      // R4 tie broken by index
      set_src(20, 1'b1, 5);
      set_src(10, 1'b1, 5);
      irq_req[20] = 1'b1; irq_req[10] = 1'b1;
      @(negedge clk);
      irq_req[20] = 1'b0; irq_req[10] = 1'b0;
      chk("R4 lower index first", int'(irq_vec), 18);
      push(18, 5, "R4 src10");
      ack();
      chk("R4 then higher index", int'(irq_vec), 28);
      push(28, 5, "R4 src20");
      ack();

      // R5 trap and top-level source in the same cycle
      cpu_prio = 3'd7;
      set_src(0, 1'b1, 7);
      trap_req[3] = 1'b1; irq_req[0] = 1'b1;
      @(negedge clk);
      trap_req[3] = 1'b0; irq_req[0] = 1'b0;
      chk("R5 trap wins", int'(irq_vec), 3);
      chk("R5 trap level", int'(irq_lvl), 8);
      push(3, 8, "R5 trap3");
      ack();
      chk("R2 masked by cpu 7", int'(irq_out), 0);
      cpu_prio = 3'd0;
      @(negedge clk);
      chk("R5 source after trap", int'(irq_vec), 8);
      push(8, 7, "R5 src0");
      ack();

      // R5 trap order
      trap_req[4] = 1'b1; trap_req[1] = 1'b1;
      @(negedge clk);
      trap_req[4] = 1'b0; trap_req[1] = 1'b0;
      chk("R5 low trap first", int'(irq_vec), 1);
      push(1, 8, "R5 trap1");
      ack();
      push(4, 8, "R5 trap4");
      ack();

      // R7 alternate table
      alt_sel = 1'b1;
      set_src(60, 1'b1, 1);
      pulse_irq(60);
      chk("R7 alt addr", int'(irq_addr), 'h18C);
      push(68, 1, "R7 src60");
      ack();
      pulse_trap(0);
      chk("R7 alt trap0 addr", int'(irq_addr), 'h104);
      push(0, 8, "R7 trap0");
      ack();
      alt_sel = 1'b0;

      // R9 acknowledge and fresh request in one cycle
      set_src(30, 1'b1, 2);
      pulse_irq(30);
      push(38, 2, "R9 src30 first");
      cpu_ack = 1'b1; irq_req[30] = 1'b1;
      @(negedge clk);
      cpu_ack = 1'b0; irq_req[30] = 1'b0;
      chk("R9 rearmed out", int'(irq_out), 1);
      chk("R9 rearmed vec", int'(irq_vec), 38);
      push(38, 2, "R9 src30 again");
      ack();
      chk("R9 drained", int'(irq_out), 0);

      // R10 ignored acknowledge and hold
      ack();
      chk("R10 idle ack vec", int'(ack_vec), 38);
      chk("R10 idle ack lvl", int'(ack_lvl), 2);
      set_src(12, 1'b1, 3);
      pulse_irq(12);
      repeat (3) @(negedge clk);
      chk("R10 hold vec", int'(ack_vec), 38);
      chk("R10 hold addr", int'(ack_addr), vaddr(38, 1'b0));
      push(20, 3, "R10 src12");
      ack();

      @(negedge clk);
      chk("R9 scoreboard empty", q.size(), 0);
      finish_run();
   end
endmodule